// File: doc/BRIEF.md
# SPI Pin and Slave-Select Controller

This block owns the pin side of an SPI port that runs as either master or slave. It keeps the port's 8-bit control register. From that register, a data-direction vector and a single-wire mode input, it decides what each of the four port pins does. A pin can be a general-purpose I/O, an SPI output or an SPI input. For an SPI output, the block sets the value and output enable, and applies open-drain drive when wired-OR mode is on.

The block drives slave-select automatically around each transfer, using a busy strobe from the shift engine. It also detects a mode fault, which happens when another master pulls slave-select low.

The shift engine and clock generator are outside the block. The block receives the serial output bit, the generated serial clock and a busy level from them. It returns to them the serial input bit and, in slave mode, the incoming clock.

Top module: `spi_pin_ctrl`

## Requirements
- R1: After reset the control register reads 0x04 and the mode-fault flag is 0. A write stores the byte, which reads back on `ctrl_o`. The bit layout, from bit 7 down to bit 0, is: interrupt enable, SPI enable, open-drain mode, master, clock polarity, clock phase, slave-select output enable, LSB-first.
- R2: Pin indices are 0=MISO, 1=MOSI, 2=SCK, 3=SS, and `ddr_i` uses the same indices. When the port is enabled as a master, the pins are set as follows:
  - MOSI carries `sdo_i` with output enable `ddr_i[1]`.
  - SCK carries `sck_gen_i` with output enable `ddr_i[2]`.
  - In normal mode, `sdi_o` follows MISO.
- R3: When the port is enabled as a slave, the pins are set as follows:
  - MISO carries `sdo_i` with output enable `ddr_i[0]`.
  - SCK is an input, and `sck_in_o` follows it.
  - In normal mode, `sdi_o` follows MOSI.
  - SS is never driven, whatever `ddr_i[3]` and slave-select output enable are.
  - `ss_sel_o` is 1 exactly when SS is low.
- R4: In a master whose code {`ddr_i[3]`, slave-select output enable} is 11, SS goes low in the same cycle `busy_i` rises. It goes high one clock after `busy_i` falls.
- R5: In a master with code 10, SS is a general-purpose output driving `gpio_out_i[3]`.
- R6: In a master with code 01, SS is an input with no fault detection. A low SS never sets the fault flag.
- R7: In single-wire mode (`bidir_i`=1), a master sends and receives on MOSI only. MISO becomes general-purpose, driving `gpio_out_i[0]` with output enable `ddr_i[0]`.
- R8: In single-wire mode, a slave sends and receives on MISO only. MOSI becomes general-purpose.
- R9: With open-drain mode set, every pin in an SPI output role drives 0 when its value is 0 and is released (enable 0) when its value is 1. General-purpose pins are unaffected.
- R10: With SPI enable at 0, every pin is general-purpose: output `gpio_out_i`, enable `ddr_i`. Also, `sdi_o`, `sck_in_o` and `ss_sel_o` are 0.
- R11: A master with code 00 that sees SS low at a clock edge does three things at that edge:
  - it sets `modf_o`;
  - it clears the master bit, and this wins over a register write in the same cycle;
  - it holds every SPI output role's enable at 0.
  
  `modf_clr_i` clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control register write data |
| ctrl_o | output | 8 | Control register contents |
| bidir_i | input | 1 | Single-wire data mode |
| ddr_i | input | 4 | Per-pin direction bits (1 = output) |
| gpio_out_i | input | 4 | Per-pin general-purpose output values |
| busy_i | input | 1 | Shift engine transfer in progress |
| sdo_i | input | 1 | Serial data from shift engine |
| sck_gen_i | input | 1 | Generated serial clock (master) |
| sdi_o | output | 1 | Serial data to shift engine |
| sck_in_o | output | 1 | Received serial clock (slave) |
| pin_in_i | input | 4 | Pin input levels |
| pin_out_o | output | 4 | Pin output values |
| pin_oe_o | output | 4 | Pin output enables |
| ss_sel_o | output | 1 | Slave is selected |
| modf_o | output | 1 | Mode-fault flag |
| modf_clr_i | input | 1 | Clear mode-fault flag |

## Verification
A mode fault and a control register write can hit the same clock edge, and both touch the master bit. The bench first enables a code-00 master with SS high. Then, in one cycle, it drives SS low and writes a new byte that keeps the master bit set and changes clock polarity. After that edge it expects the written byte with the master bit cleared, the fault flag set and the MISO enable held off. This shows that the write landed and the fault still took priority on the one bit they share.

// File: rtl/spi_pin_pkg.sv
package spi_pin_pkg;

  localparam int PIN_CNT  = 4;
  localparam int PIN_MISO = 0;
  localparam int PIN_MOSI = 1;
  localparam int PIN_SCK  = 2;
  localparam int PIN_SS   = 3;

  typedef struct packed {
    logic irq_en;
    logic spe;
    logic wom;
    logic mstr;
    logic cpol;
    logic cpha;
    logic ssoe;
    logic lsbf;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {
    SS_IN_FAULT = 2'b00,
    SS_IN       = 2'b01,
    SS_GPIO     = 2'b10,
    SS_AUTO     = 2'b11
  } ss_role_e;

  typedef enum logic [1:0] {
    FN_GPIO    = 2'b00,
    FN_SPI_OUT = 2'b01,
    FN_SPI_IN  = 2'b10
  } pin_fn_e;

endpackage

// File: rtl/spi_ctrl_reg.sv
module spi_ctrl_reg
  import spi_pin_pkg::*;
#(
  parameter logic [CTRL_W-1:0] RST_VAL = 8'h04
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              fault_set_i,
  input  logic              modf_clr_i,
  output ctrl_t             ctrl_o,
  output logic              modf_o
);

  ctrl_t ctrl_q, ctrl_d;
  logic  modf_q;

  always_comb begin
    ctrl_d = ctrl_q;
    if (we_i) ctrl_d = ctrl_t'(wdata_i);
    // fault overrides a concurrent write on the master bit
    if (fault_set_i) ctrl_d.mstr = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= ctrl_t'(RST_VAL);
      modf_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      if (fault_set_i)     modf_q <= 1'b1;
      else if (modf_clr_i) modf_q <= 1'b0;
    end
  end

  assign ctrl_o = ctrl_q;
  assign modf_o = modf_q;

endmodule

// File: rtl/spi_ss_ctrl.sv
module spi_ss_ctrl
  import spi_pin_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     spe_i,
  input  logic     mstr_i,
  input  logic     ssoe_i,
  input  logic     ss_dir_i,
  input  logic     ss_pin_i,
  input  logic     busy_i,
  output ss_role_e role_o,
  output logic     ss_auto_o,
  output logic     fault_set_o,
  output logic     ss_sel_o
);

  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= busy_i;
  end

  always_comb begin
    if (!mstr_i) role_o = SS_IN;
    else begin
      unique case ({ss_dir_i, ssoe_i})
        2'b00:   role_o = SS_IN_FAULT;
        2'b01:   role_o = SS_IN;
        2'b10:   role_o = SS_GPIO;
        default: role_o = SS_AUTO;
      endcase
    end
  end

  // low from the first busy cycle, high one cycle after busy drops
  assign ss_auto_o   = ~(busy_i | busy_q);
  assign fault_set_o = spe_i & mstr_i & (role_o == SS_IN_FAULT) & ~ss_pin_i;
  assign ss_sel_o    = spe_i & ~mstr_i & ~ss_pin_i;

endmodule

// File: rtl/spi_data_route.sv
module spi_data_route
  import spi_pin_pkg::*;
(
  input  logic                    spe_i,
  input  logic                    mstr_i,
  input  logic                    bidir_i,
  input  logic [PIN_CNT-1:0]      ddr_i,
  input  logic                    sdo_i,
  input  logic                    sck_gen_i,
  input  logic [PIN_CNT-1:0]      pin_in_i,
  input  ss_role_e                ss_role_i,
  input  logic                    ss_auto_i,
  output logic [PIN_CNT-1:0][1:0] fn_o,
  output logic [PIN_CNT-1:0]      val_o,
  output logic [PIN_CNT-1:0]      en_o,
  output logic                    sdi_o,
  output logic                    sck_in_o
);

  always_comb begin
    for (int k = 0; k < PIN_CNT; k++) begin
      fn_o[k]  = FN_GPIO;
      val_o[k] = 1'b0;
      en_o[k]  = 1'b0;
    end
    sdi_o    = 1'b0;
    sck_in_o = 1'b0;

    if (spe_i) begin
      if (mstr_i) begin
        fn_o[PIN_MOSI]  = FN_SPI_OUT;
        val_o[PIN_MOSI] = sdo_i;
        en_o[PIN_MOSI]  = ddr_i[PIN_MOSI];
        fn_o[PIN_SCK]   = FN_SPI_OUT;
        val_o[PIN_SCK]  = sck_gen_i;
        en_o[PIN_SCK]   = ddr_i[PIN_SCK];
        if (bidir_i) begin
          fn_o[PIN_MISO] = FN_GPIO;
          sdi_o          = pin_in_i[PIN_MOSI];
        end else begin
          fn_o[PIN_MISO] = FN_SPI_IN;
          sdi_o          = pin_in_i[PIN_MISO];
        end
      end else begin
        fn_o[PIN_MISO]  = FN_SPI_OUT;
        val_o[PIN_MISO] = sdo_i;
        en_o[PIN_MISO]  = ddr_i[PIN_MISO];
        fn_o[PIN_SCK]   = FN_SPI_IN;
        sck_in_o        = pin_in_i[PIN_SCK];
        if (bidir_i) begin
          fn_o[PIN_MOSI] = FN_GPIO;
          sdi_o          = pin_in_i[PIN_MISO];
        end else begin
          fn_o[PIN_MOSI] = FN_SPI_IN;
          sdi_o          = pin_in_i[PIN_MOSI];
        end
      end

      unique case (ss_role_i)
        SS_GPIO: fn_o[PIN_SS] = FN_GPIO;
        SS_AUTO: begin
          fn_o[PIN_SS]  = FN_SPI_OUT;
          val_o[PIN_SS] = ss_auto_i;
          en_o[PIN_SS]  = 1'b1;
        end
        default: fn_o[PIN_SS] = FN_SPI_IN;
      endcase
    end
  end

endmodule

// File: rtl/spi_pin_drv.sv
module spi_pin_drv
  import spi_pin_pkg::*;
(
  input  logic [1:0] fn_i,
  input  logic       val_i,
  input  logic       en_i,
  input  logic       gpio_val_i,
  input  logic       gpio_dir_i,
  input  logic       wom_i,
  input  logic       modf_i,
  output logic       out_o,
  output logic       oe_o
);

  always_comb begin
    out_o = 1'b0;
    oe_o  = 1'b0;
    if (fn_i == FN_GPIO) begin
      out_o = gpio_val_i;
      oe_o  = gpio_dir_i;
    end else if (fn_i == FN_SPI_OUT) begin
      // open-drain: pull low only, release for high
      out_o = wom_i ? 1'b0 : val_i;
      oe_o  = en_i & ~modf_i & (~wom_i | ~val_i);
    end
  end

endmodule

// File: rtl/spi_pin_ctrl.sv
module spi_pin_ctrl
  import spi_pin_pkg::*;
#(
  parameter logic [CTRL_W-1:0] CTRL_RST = 8'h04
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_we_i,
  input  logic [CTRL_W-1:0]  ctrl_wdata_i,
  output logic [CTRL_W-1:0]  ctrl_o,
  input  logic               bidir_i,
  input  logic [PIN_CNT-1:0] ddr_i,
  input  logic [PIN_CNT-1:0] gpio_out_i,
  input  logic               busy_i,
  input  logic               sdo_i,
  input  logic               sck_gen_i,
  output logic               sdi_o,
  output logic               sck_in_o,
  input  logic [PIN_CNT-1:0] pin_in_i,
  output logic [PIN_CNT-1:0] pin_out_o,
  output logic [PIN_CNT-1:0] pin_oe_o,
  output logic               ss_sel_o,
  output logic               modf_o,
  input  logic               modf_clr_i
);

  ctrl_t                    ctrl;
  logic                     modf;
  logic                     fault_set;
  ss_role_e                 ss_role;
  logic                     ss_auto;
  logic [PIN_CNT-1:0][1:0]  fn;
  logic [PIN_CNT-1:0]       val;
  logic [PIN_CNT-1:0]       en;

  spi_ctrl_reg #(.RST_VAL(CTRL_RST)) u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (ctrl_we_i),
    .wdata_i     (ctrl_wdata_i),
    .fault_set_i (fault_set),
    .modf_clr_i  (modf_clr_i),
    .ctrl_o      (ctrl),
    .modf_o      (modf)
  );

  spi_ss_ctrl u_ss (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .spe_i       (ctrl.spe),
    .mstr_i      (ctrl.mstr),
    .ssoe_i      (ctrl.ssoe),
    .ss_dir_i    (ddr_i[PIN_SS]),
    .ss_pin_i    (pin_in_i[PIN_SS]),
    .busy_i      (busy_i),
    .role_o      (ss_role),
    .ss_auto_o   (ss_auto),
    .fault_set_o (fault_set),
    .ss_sel_o    (ss_sel_o)
  );

  spi_data_route u_route (
    .spe_i     (ctrl.spe),
    .mstr_i    (ctrl.mstr),
    .bidir_i   (bidir_i),
    .ddr_i     (ddr_i),
    .sdo_i     (sdo_i),
    .sck_gen_i (sck_gen_i),
    .pin_in_i  (pin_in_i),
    .ss_role_i (ss_role),
    .ss_auto_i (ss_auto),
    .fn_o      (fn),
    .val_o     (val),
    .en_o      (en),
    .sdi_o     (sdi_o),
    .sck_in_o  (sck_in_o)
  );

  for (genvar k = 0; k < PIN_CNT; k++) begin : g_pin
    spi_pin_drv u_drv (
      .fn_i       (fn[k]),
      .val_i      (val[k]),
      .en_i       (en[k]),
      .gpio_val_i (gpio_out_i[k]),
      .gpio_dir_i (ddr_i[k]),
      .wom_i      (ctrl.wom),
      .modf_i     (modf),
      .out_o      (pin_out_o[k]),
      .oe_o       (pin_oe_o[k])
    );
  end

  assign ctrl_o = ctrl;
  assign modf_o = modf;

endmodule

// File: rtl/spi_pin_ctrl_chk.sv
module spi_pin_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ctrl_we_i,
  input logic [7:0] ctrl_o,
  input logic [3:0] ddr_i,
  input logic [3:0] gpio_out_i,
  input logic       busy_i,
  input logic [3:0] pin_in_i,
  input logic [3:0] pin_out_o,
  input logic [3:0] pin_oe_o,
  input logic       ss_sel_o,
  input logic       modf_o,
  input logic       modf_clr_i
);

  logic spe, wom, mstr, ssoe, auto_cfg, fault_cfg, code01_cfg;
  assign spe        = ctrl_o[6];
  assign wom        = ctrl_o[5];
  assign mstr       = ctrl_o[4];
  assign ssoe       = ctrl_o[1];
  assign auto_cfg   = spe & mstr & ddr_i[3] & ssoe;
  assign fault_cfg  = spe & mstr & ~ddr_i[3] & ~ssoe;
  assign code01_cfg = spe & mstr & ~ddr_i[3] & ssoe;

  p_slave_ss_in_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spe && !mstr) |-> !pin_oe_o[3]);

  p_ss_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_sel_o |-> (!mstr && !pin_in_i[3]));

  p_ss_low_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_cfg && busy_i) |-> !pin_out_o[3]);

  p_ss_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_cfg && busy_i && !ctrl_we_i) |=> !pin_out_o[3]);

  p_no_fault_01_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code01_cfg && !modf_o && !ctrl_we_i) |=> !modf_o);

  p_od_mosi_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spe && wom && mstr) |-> !(pin_oe_o[1] && pin_out_o[1]));

  p_off_gpio_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spe |-> (pin_oe_o == ddr_i && pin_out_o == gpio_out_i));

  p_fault_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_cfg && !pin_in_i[3]) |=> (modf_o && !mstr));

  p_fault_oe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (modf_o && spe && !mstr) |-> !pin_oe_o[0]);

  p_fault_clr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (modf_o && modf_clr_i) |=> !modf_o);

endmodule

bind spi_pin_ctrl spi_pin_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ctrl_we_i  (ctrl_we_i),
  .ctrl_o     (ctrl_o),
  .ddr_i      (ddr_i),
  .gpio_out_i (gpio_out_i),
  .busy_i     (busy_i),
  .pin_in_i   (pin_in_i),
  .pin_out_o  (pin_out_o),
  .pin_oe_o   (pin_oe_o),
  .ss_sel_o   (ss_sel_o),
  .modf_o     (modf_o),
  .modf_clr_i (modf_clr_i)
);

// File: tb/tb_spi_pin_ctrl.sv
module tb_spi_pin_ctrl;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctrl_we_i = 1'b0;
  logic [7:0] ctrl_wdata_i = '0;
  logic [7:0] ctrl_o;
  logic       bidir_i = 1'b0;
  logic [3:0] ddr_i = '0;
  logic [3:0] gpio_out_i = '0;
  logic       busy_i = 1'b0;
  logic       sdo_i = 1'b0;
  logic       sck_gen_i = 1'b0;
  logic       sdi_o, sck_in_o;
  logic [3:0] pin_in_i = 4'hF;
  logic [3:0] pin_out_o, pin_oe_o;
  logic       ss_sel_o, modf_o;
  logic       modf_clr_i = 1'b0;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  spi_pin_ctrl dut (.*);

  always #2 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk_i);
    ctrl_we_i = 1'b1;
    ctrl_wdata_i = v;
    @(negedge clk_i);
    ctrl_we_i = 1'b0;
  endtask

  // expected pin behaviour from the requirements; modf=0, busy idle
  task automatic check_cfg(input logic [7:0] c, input string req);
    logic spe, wom, mstr, ssoe;
    logic [3:0] eo, eoe;
    logic esdi, esck, esel;
    logic [1:0] fnk [4];
    logic [3:0] v, en;
    spe = c[6]; wom = c[5]; mstr = c[4]; ssoe = c[1];
    v = '0; en = '0;
    for (int k = 0; k < 4; k++) fnk[k] = 2'd0;
    esdi = 1'b0; esck = 1'b0; esel = 1'b0;
    if (spe) begin
      if (mstr) begin
        fnk[1] = 2'd1; v[1] = sdo_i; en[1] = ddr_i[1];
        fnk[2] = 2'd1; v[2] = sck_gen_i; en[2] = ddr_i[2];
        fnk[0] = bidir_i ? 2'd0 : 2'd2;
        esdi = bidir_i ? pin_in_i[1] : pin_in_i[0];
        case ({ddr_i[3], ssoe})
          2'b10: fnk[3] = 2'd0;
          2'b11: begin fnk[3] = 2'd1; v[3] = 1'b1; en[3] = 1'b1; end
          default: fnk[3] = 2'd2;
        endcase
      end else begin
        fnk[0] = 2'd1; v[0] = sdo_i; en[0] = ddr_i[0];
        fnk[2] = 2'd2;
        fnk[1] = bidir_i ? 2'd0 : 2'd2;
        esdi = bidir_i ? pin_in_i[0] : pin_in_i[1];
        esck = pin_in_i[2];
        esel = ~pin_in_i[3];
        fnk[3] = 2'd2;
      end
    end
    for (int k = 0; k < 4; k++) begin
      case (fnk[k])
        2'd0: begin eo[k] = gpio_out_i[k]; eoe[k] = ddr_i[k]; end
        2'd1: begin eo[k] = wom ? 1'b0 : v[k]; eoe[k] = en[k] & (~wom | ~v[k]); end
        default: begin eo[k] = 1'b0; eoe[k] = 1'b0; end
      endcase
    end
    chk(pin_out_o == eo, req, "pin_out", {28'd0, pin_out_o}, {28'd0, eo});
    chk(pin_oe_o == eoe, req, "pin_oe", {28'd0, pin_oe_o}, {28'd0, eoe});
    chk({sdi_o, sck_in_o, ss_sel_o} == {esdi, esck, esel}, req, "sdi/sck_in/ss_sel",
        {29'd0, sdi_o, sck_in_o, ss_sel_o}, {29'd0, esdi, esck, esel});
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] c;
    string req;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(ctrl_o == 8'h04, "R1", "reset ctrl", {24'd0, ctrl_o}, 32'h04);
    chk(modf_o == 1'b0, "R1", "reset modf", {31'd0, modf_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 disabled: all gpio
    ddr_i = 4'b1010; gpio_out_i = 4'b0110;
    #1 check_cfg(ctrl_o, "R10");

    // sweep: spe, mstr, bidir, wom, ddr, ssoe, two pin patterns
    for (int cfg = 0; cfg < 512; cfg++) begin
      c = {cfg[0] ^ cfg[1], cfg[0], cfg[3], cfg[1], cfg[2], cfg[4], cfg[8], cfg[5]};
      wr_ctrl(c);
      chk(ctrl_o == c, "R1", "readback", {24'd0, ctrl_o}, {24'd0, c});
      bidir_i = cfg[2];
      ddr_i = cfg[7:4];
      if (!cfg[0])        req = "R10";
      else if (cfg[3])    req = "R9";
      else if (cfg[2])    req = cfg[1] ? "R7" : "R8";
      else if (!cfg[1])   req = "R3";
      else if (cfg[7] && !cfg[8]) req = "R5";
      else                req = "R2";
      for (int p = 0; p < 2; p++) begin
        @(negedge clk_i);
        gpio_out_i = p ? 4'b1010 : 4'b0101;
        sdo_i      = p ? 1'b0 : 1'b1;
        sck_gen_i  = p ? 1'b1 : 1'b0;
        pin_in_i   = p ? 4'b1101 : 4'b1010;
        #1 check_cfg(c, req);
      end
    end

    // R3 slave selected when SS low
    bidir_i = 1'b0; ddr_i = 4'b1111;
    wr_ctrl(8'h40);
    @(negedge clk_i); pin_in_i = 4'b0111;
    #1 chk(ss_sel_o == 1'b1, "R3", "ss_sel low", {31'd0, ss_sel_o}, 1);
    chk(pin_oe_o[3] == 1'b0, "R3", "ss oe slave", {31'd0, pin_oe_o[3]}, 0);

    // R4 auto slave-select timing
    pin_in_i = 4'hF;
    wr_ctrl(8'h52);
    #1 chk(pin_out_o[3] == 1'b1 && pin_oe_o[3], "R4", "ss idle", {30'd0, pin_oe_o[3], pin_out_o[3]}, 3);
    @(negedge clk_i); busy_i = 1'b1;
    #1 chk(pin_out_o[3] == 1'b0, "R4", "ss low at busy", {31'd0, pin_out_o[3]}, 0);
    repeat (3) @(negedge clk_i);
    #1 chk(pin_out_o[3] == 1'b0, "R4", "ss low held", {31'd0, pin_out_o[3]}, 0);
    @(negedge clk_i); busy_i = 1'b0;
    #1 chk(pin_out_o[3] == 1'b0, "R4", "ss low after fall", {31'd0, pin_out_o[3]}, 0);
    @(posedge clk_i); #1
    chk(pin_out_o[3] == 1'b1, "R4", "ss high next cycle", {31'd0, pin_out_o[3]}, 1);

    // R6 code 01: no fault
    ddr_i = 4'b0111;
    @(negedge clk_i); pin_in_i = 4'b0111;
    repeat (3) @(negedge clk_i);
    chk(modf_o == 1'b0 && ctrl_o == 8'h52, "R6", "no fault code01", {23'd0, modf_o, ctrl_o}, 32'h52);
    pin_in_i = 4'hF;

    // R11 fault, code 00
    wr_ctrl(8'h50);
    #1 chk(pin_oe_o[1] == 1'b1, "R11", "mosi oe before", {31'd0, pin_oe_o[1]}, 1);
    @(negedge clk_i); pin_in_i = 4'b0111;
    #1 chk(modf_o == 1'b0, "R11", "flag not yet", {31'd0, modf_o}, 0);
    @(posedge clk_i); #1
    chk(modf_o == 1'b1 && ctrl_o == 8'h40, "R11", "fault set", {23'd0, modf_o, ctrl_o}, 32'h140);
    chk(pin_oe_o[1:0] == 2'b00, "R11", "spi oe off", {30'd0, pin_oe_o[1:0]}, 0);
    @(negedge clk_i); pin_in_i = 4'hF; modf_clr_i = 1'b1;
    @(negedge clk_i); modf_clr_i = 1'b0;
    chk(modf_o == 1'b0 && pin_oe_o[0] == 1'b1, "R11", "cleared", {30'd0, modf_o, pin_oe_o[0]}, 1);

    // R11 fault wins over a same-cycle write
    wr_ctrl(8'h50);
    @(negedge clk_i); pin_in_i = 4'b0111; ctrl_we_i = 1'b1; ctrl_wdata_i = 8'h58;
    @(negedge clk_i); ctrl_we_i = 1'b0;
    chk(ctrl_o == 8'h48 && modf_o, "R11", "fault vs write", {23'd0, modf_o, ctrl_o}, 32'h148);
    chk(pin_oe_o[0] == 1'b0, "R11", "miso oe off", {31'd0, pin_oe_o[0]}, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule